// File: doc/BRIEF.md
# Instruction Predecoder and Target Generator

This block sits in the fetch path of an 8-bit microcontroller whose instructions are one to three bytes long. Given the first instruction byte, the two bytes after it and the 16-bit address of the first byte, it works out how long the instruction is and what kind of operand it carries. It pulls the operand fields out of the bytes: a 9-bit data address, an indirect pointer index, a bit number and an immediate. It also gives the address of the following instruction and, for jumps, branches and calls, the destination address.

The decoder does not execute instructions, read data memory or judge branch conditions. It computes where a branch would go, and a later stage decides whether it does. Inputs are taken on a clock edge when `in_valid` is high. The results appear one cycle later together with `out_valid`, and they hold until the next accepted input.

Every one of the 256 opcode values has a defined meaning, so each one gets a length and a class.

Top module: `insn_predecode`

## Requirements
- R1: `out_len` is 3 for the direct-address move with immediate (op 0x22/0x23), the compare-and-branch forms (0x31, 0x41, 0x32/0x33, 0x42/0x43, 0x34-0x37, 0x44-0x47), the direct decrement-and-branch (0x52/0x53), the bit-test branches (0x48-0x9F with op bit 3 set), the 16-bit relative forms (0x10, 0x11) and the 16-bit absolute forms (0x20, 0x21). It is 1 for implied opcodes and for indirect forms without a trailing byte. Every other opcode has length 2.
- R2: `out_mode` encodes the operand class as 0 implied, 1 immediate, 2 direct, 3 indirect, 4 bit-addressed, 5 absolute target, 6 relative-only target. Low nibble 2-3 is direct, low nibble 4-7 is indirect, and op bit 3 set with high nibble 4-F is bit-addressed.
- R3: `out_d9` is {op bit 0, byte1} for direct, and {op bit 4, byte1} for bit-addressed. `out_ri` is op bits 1:0 for indirect. `out_bit` is op bits 2:0 for bit-addressed. `out_imm` is byte2 for 0x22/0x23 and byte1 for the other immediate-carrying forms. Each field is 0 where it does not apply.
- R4: `out_next_pc` equals pc + length, modulo 65536.
- R5: For an 8-bit relative target, the offset is byte1 in two-byte forms and byte2 in three-byte forms. It is sign-extended and added to the next address.
- R6: For 0x10 and 0x11 the target is next + {byte2, byte1} - 1, modulo 65536.
- R7: For 0x20 and 0x21 the target is {byte1, byte2}, with the high byte first.
- R8: For 12-bit absolute forms (op bit 3 set, high nibble 0-3) the target is {next[15:12], op bit 4, op bits 2:0, byte1}.
- R9: `out_has_target` is high exactly for opcodes with a target (R5-R8). When it is low, `out_target` is 0.
- R10: `out_valid` follows `in_valid` by one cycle. When `in_valid` is low, the data outputs hold their values. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Accept the inputs on this edge |
| opcode | input | 8 | First instruction byte |
| byte1 | input | 8 | Second instruction byte |
| byte2 | input | 8 | Third instruction byte |
| pc | input | 16 | Address of the first byte |
| out_valid | output | 1 | Outputs below belong to an accepted input |
| out_len | output | 2 | Instruction length, 1 to 3 |
| out_mode | output | 3 | Operand class code |
| out_d9 | output | 9 | Direct data address |
| out_ri | output | 2 | Indirect pointer index |
| out_bit | output | 3 | Bit number |
| out_imm | output | 8 | Immediate value |
| out_has_target | output | 1 | A target address is present |
| out_target | output | 16 | Jump, branch or call destination |
| out_next_pc | output | 16 | Address of the following instruction |

## Verification
Every one of the 256 opcodes is driven once with random trailing bytes and a random address. This separates the length, class and field choice of each opcode group. A fixed-seed random run follows, with random addresses and offsets, which separates correct sign extension and modular arithmetic from near-misses. Directed cases pick values that tell the target rules apart:
- an 8-bit backward branch;
- a 16-bit relative target with a zero offset, where the minus one is the only change;
- a 16-bit relative target that wraps past the top of memory;
- a 12-bit absolute target whose following address crosses into the next 4K page;
- an absolute far target whose two bytes differ, which exposes a swapped byte order.

A held-input phase shows that new inputs are ignored while `in_valid` is low.

// File: rtl/insn_predecode.sv
module insn_predecode (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  opcode,
  input  logic [7:0]  byte1,
  input  logic [7:0]  byte2,
  input  logic [15:0] pc,
  output logic        out_valid,
  output logic [1:0]  out_len,
  output logic [2:0]  out_mode,
  output logic [8:0]  out_d9,
  output logic [1:0]  out_ri,
  output logic [2:0]  out_bit,
  output logic [7:0]  out_imm,
  output logic        out_has_target,
  output logic [15:0] out_target,
  output logic [15:0] out_next_pc
);
  localparam logic [2:0] M_IMP = 3'd0, M_IMM = 3'd1, M_DIR = 3'd2, M_IND = 3'd3,
                         M_BIT = 3'd4, M_ABS = 3'd5, M_REL = 3'd6;
  localparam logic [2:0] T_NONE = 3'd0, T_R8A = 3'd1, T_R8B = 3'd2,
                         T_R16 = 3'd3, T_A16 = 3'd4, T_A12 = 3'd5;
  localparam logic [1:0] I_NONE = 2'd0, I_B1 = 2'd1, I_B2 = 2'd2;

  logic [3:0]  hi;
  logic [1:0]  len;
  logic [2:0]  mode, tk;
  logic [1:0]  isel;
  logic [15:0] nxt, tgt;
  logic [8:0]  d9;
  logic [7:0]  imm;

  assign hi = opcode[7:4];

  always_comb begin
    len = 2'd1; mode = M_IMP; tk = T_NONE; isel = I_NONE;
    if (opcode[3]) begin
      case (hi[3:1])
        3'd0, 3'd1:       begin len = 2'd2; mode = M_ABS; tk = T_A12; end
        3'd2, 3'd3, 3'd4: begin len = 2'd3; mode = M_BIT; tk = T_R8B; end
        default:          begin len = 2'd2; mode = M_BIT; end
      endcase
    end else if (opcode[2]) begin
      mode = M_IND;
      case (hi)
        4'h2:       begin len = 2'd2; isel = I_B1; end
        4'h3, 4'h4: begin len = 2'd3; isel = I_B1; tk = T_R8B; end
        4'h5:       begin len = 2'd2; tk = T_R8A; end
        default:    len = 2'd1;
      endcase
    end else if (opcode[1]) begin
      mode = M_DIR;
      case (hi)
        4'h2:             begin len = 2'd3; isel = I_B2; end
        4'h3, 4'h4, 4'h5: begin len = 2'd3; tk = T_R8B; end
        default:          len = 2'd2;
      endcase
    end else if (opcode[0]) begin
      case (hi)
        4'h0:       begin len = 2'd2; mode = M_REL; tk = T_R8A; end
        4'h1:       begin len = 2'd3; mode = M_REL; tk = T_R16; end
        4'h2:       begin len = 2'd3; mode = M_ABS; tk = T_A16; end
        4'h3, 4'h4: begin len = 2'd3; mode = M_IMM; isel = I_B1; tk = T_R8B; end
        4'h5, 4'hC: len = 2'd1;
        4'h6, 4'h7: begin len = 2'd2; mode = M_DIR; end
        default:    begin len = 2'd2; mode = M_IMM; isel = I_B1; end
      endcase
    end else begin
      case (hi)
        4'h1:       begin len = 2'd3; mode = M_REL; tk = T_R16; end
        4'h2:       begin len = 2'd3; mode = M_ABS; tk = T_A16; end
        4'h6, 4'h7: begin len = 2'd2; mode = M_DIR; end
        4'h8, 4'h9: begin len = 2'd2; mode = M_REL; tk = T_R8A; end
        default:    len = 2'd1;
      endcase
    end
  end

  assign nxt = pc + {14'd0, len};

  always_comb begin
    case (tk)
      T_R8A:   tgt = nxt + {{8{byte1[7]}}, byte1};
      T_R8B:   tgt = nxt + {{8{byte2[7]}}, byte2};
      T_R16:   tgt = nxt + {byte2, byte1} - 16'd1;
      T_A16:   tgt = {byte1, byte2};
      T_A12:   tgt = {nxt[15:12], opcode[4], opcode[2:0], byte1};
      default: tgt = 16'd0;
    endcase
  end

  assign d9  = (mode == M_DIR) ? {opcode[0], byte1} :
               (mode == M_BIT) ? {opcode[4], byte1} : 9'd0;
  assign imm = (isel == I_B1) ? byte1 : (isel == I_B2) ? byte2 : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_len        <= 2'd0;
      out_mode       <= 3'd0;
      out_d9         <= 9'd0;
      out_ri         <= 2'd0;
      out_bit        <= 3'd0;
      out_imm        <= 8'd0;
      out_has_target <= 1'b0;
      out_target     <= 16'd0;
      out_next_pc    <= 16'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_len        <= len;
        out_mode       <= mode;
        out_d9         <= d9;
        out_ri         <= (mode == M_IND) ? opcode[1:0] : 2'd0;
        out_bit        <= (mode == M_BIT) ? opcode[2:0] : 3'd0;
        out_imm        <= imm;
        out_has_target <= (tk != T_NONE);
        out_target     <= tgt;
        out_next_pc    <= nxt;
      end
    end
  end
endmodule

// File: rtl/insn_predecode_chk.sv
module insn_predecode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] pc,
  input logic        out_valid,
  input logic [1:0]  out_len,
  input logic [2:0]  out_mode,
  input logic [1:0]  out_ri,
  input logic [2:0]  out_bit,
  input logic        out_has_target,
  input logic [15:0] out_target,
  input logic [15:0] out_next_pc
);
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != 2'd0)); // R1
  AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mode != 3'd7)); // R2
  AST_RI_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode != 3'd3) |-> (out_ri == 2'd0)); // R3
  AST_BIT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode != 3'd4) |-> (out_bit == 3'd0)); // R3
  AST_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_next_pc == $past(pc) + {14'd0, out_len})); // R4
  AST_NO_TARGET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_has_target |-> (out_target == 16'd0)); // R9
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R10
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_target) && $stable(out_next_pc) && $stable(out_len))); // R10
endmodule

bind insn_predecode insn_predecode_chk u_chk (.*);

// File: tb/insn_predecode_tb.sv
`timescale 1ns/1ps
module insn_predecode_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'd0, byte1 = 8'd0, byte2 = 8'd0;
  logic [15:0] pc = 16'd0;
  logic        out_valid, out_has_target;
  logic [1:0]  out_len, out_ri;
  logic [2:0]  out_mode, out_bit;
  logic [8:0]  out_d9;
  logic [7:0]  out_imm;
  logic [15:0] out_target, out_next_pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0]  e_len, e_ri;
  logic [2:0]  e_mode, e_bit;
  logic [8:0]  e_d9;
  logic [7:0]  e_imm;
  logic        e_ht;
  logic [15:0] e_tgt, e_nxt;
  string       e_ttag;

  always #2 clk = ~clk;

  insn_predecode u_dut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%02h b1=%02h b2=%02h pc=%04h actual=%0h expected=%0h",
               tag, opcode, byte1, byte2, pc, act, exp);
    end
  endtask

  function automatic logic [15:0] sx(input logic [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  task automatic model(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [15:0] a);
    int kind; // 0 none,1 rel8 b1,2 rel8 b2,3 rel16,4 abs16,5 abs12
    int isel; // 0 none,1 b1,2 b2
    kind = 0; isel = 0;
    casez (op)
      8'b000?_1???, 8'b001?_1???: begin e_len = 2; e_mode = 5; kind = 5; end
      8'b010?_1???, 8'b011?_1???, 8'b100?_1???: begin e_len = 3; e_mode = 4; kind = 2; end
      8'b101?_1???, 8'b110?_1???, 8'b111?_1???: begin e_len = 2; e_mode = 4; end
      8'b0010_01??: begin e_len = 2; e_mode = 3; isel = 1; end
      8'b0011_01??, 8'b0100_01??: begin e_len = 3; e_mode = 3; isel = 1; kind = 2; end
      8'b0101_01??: begin e_len = 2; e_mode = 3; kind = 1; end
      8'b????_01??: begin e_len = 1; e_mode = 3; end
      8'b0010_001?: begin e_len = 3; e_mode = 2; isel = 2; end
      8'b0011_001?, 8'b0100_001?, 8'b0101_001?: begin e_len = 3; e_mode = 2; kind = 2; end
      8'b????_001?: begin e_len = 2; e_mode = 2; end
      8'h01: begin e_len = 2; e_mode = 6; kind = 1; end
      8'h11, 8'h10: begin e_len = 3; e_mode = 6; kind = 3; end
      8'h21, 8'h20: begin e_len = 3; e_mode = 5; kind = 4; end
      8'h31, 8'h41: begin e_len = 3; e_mode = 1; isel = 1; kind = 2; end
      8'h51, 8'hC1: begin e_len = 1; e_mode = 0; end
      8'h61, 8'h71, 8'h60, 8'h70: begin e_len = 2; e_mode = 2; end
      8'b????_0001: begin e_len = 2; e_mode = 1; isel = 1; end
      8'h80, 8'h90: begin e_len = 2; e_mode = 6; kind = 1; end
      default: begin e_len = 1; e_mode = 0; end
    endcase
    e_nxt = a + 16'(e_len);
    e_ht  = (kind != 0);
    case (kind)
      1: begin e_tgt = e_nxt + sx(b1); e_ttag = "R5"; end
      2: begin e_tgt = e_nxt + sx(b2); e_ttag = "R5"; end
      3: begin e_tgt = e_nxt + {b2, b1} - 16'd1; e_ttag = "R6"; end
      4: begin e_tgt = {b1, b2}; e_ttag = "R7"; end
      5: begin e_tgt = {e_nxt[15:12], op[4], op[2:0], b1}; e_ttag = "R8"; end
      default: begin e_tgt = 16'd0; e_ttag = "R9"; end
    endcase
    e_d9  = (e_mode == 2) ? {op[0], b1} : (e_mode == 4) ? {op[4], b1} : 9'd0;
    e_ri  = (e_mode == 3) ? op[1:0] : 2'd0;
    e_bit = (e_mode == 4) ? op[2:0] : 3'd0;
    e_imm = (isel == 1) ? b1 : (isel == 2) ? b2 : 8'd0;
  endtask

  task automatic compare_all();
    chk("R10 out_valid", 16'(out_valid), 16'd1);
    chk("R1 out_len", 16'(out_len), 16'(e_len));
    chk("R2 out_mode", 16'(out_mode), 16'(e_mode));
    chk("R3 out_d9", 16'(out_d9), 16'(e_d9));
    chk("R3 out_ri", 16'(out_ri), 16'(e_ri));
    chk("R3 out_bit", 16'(out_bit), 16'(e_bit));
    chk("R3 out_imm", 16'(out_imm), 16'(e_imm));
    chk("R4 out_next_pc", out_next_pc, e_nxt);
    chk("R9 out_has_target", 16'(out_has_target), 16'(e_ht));
    chk({e_ttag, " out_target"}, out_target, e_tgt);
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic run(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                     input logic [15:0] a);
    opcode = op; byte1 = b1; byte2 = b2; pc = a; in_valid = 1'b1;
    model(op, b1, b2, a);
    @(negedge clk);
    in_valid = 1'b0;
    compare_all();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // reset state
    chk("R10 reset out_valid", 16'(out_valid), 16'd0);
    chk("R10 reset out_target", out_target, 16'd0);
    chk("R10 reset out_len", 16'(out_len), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // every opcode once
    for (int i = 0; i < 256; i++)
      run(8'(i), 8'($urandom), 8'($urandom), 16'($urandom));

    // directed corners
    run(8'h01, 8'h80, 8'h00, 16'h0010);           // R5 backward: FF92
    chk("R5 backward branch", out_target, 16'hFF92);
    run(8'h11, 8'h00, 8'h00, 16'h0000);           // R6 zero offset: 0002
    chk("R6 minus one", out_target, 16'h0002);
    run(8'h11, 8'h05, 8'h00, 16'hFFFE);           // R6 wrap: next 0001, tgt 0005
    chk("R6 wrap", out_target, 16'h0005);
    run(8'h10, 8'h00, 8'h10, 16'hF800);           // R6 call: F803+1000-1 = 0802
    chk("R6 call wrap", out_target, 16'h0802);
    run(8'h20, 8'h12, 8'h34, 16'h4000);           // R7 high byte first
    chk("R7 byte order", out_target, 16'h1234);
    run(8'h2F, 8'h34, 8'h00, 16'h0FFF);           // R8 page crossing: next 1001
    chk("R8 page from next", out_target, 16'h1734);
    run(8'h18, 8'hAB, 8'h00, 16'h5000);           // R8 call with a11 set
    chk("R8 a11 bit", out_target, 16'h58AB);
    run(8'h00, 8'h00, 8'h00, 16'hFFFF);           // R4 wrap
    chk("R4 next wrap", out_next_pc, 16'h0000);
    run(8'h7E, 8'h22, 8'hFE, 16'h0100);           // R5 bit branch, byte2 offset
    chk("R5 third byte offset", out_target, 16'h0101);

    // random stream
    for (int i = 0; i < 400; i++)
      run(8'($urandom), 8'($urandom), 8'($urandom), 16'($urandom));

    // ignored inputs while in_valid is low (R10)
    run(8'h21, 8'hBE, 8'hEF, 16'h0200);
    opcode = 8'h01; byte1 = 8'h7F; byte2 = 8'h00; pc = 16'h9000; in_valid = 1'b0;
    @(negedge clk);
    chk("R10 valid low", 16'(out_valid), 16'd0);
    chk("R10 target held", out_target, 16'hBEEF);
    chk("R10 next held", out_next_pc, 16'h0203);
    chk("R10 len held", 16'(out_len), 16'd3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule